// File: doc/BRIEF.md
# Serial DAC Readback Receiver

This block reads a DAC setting back from a remote front-end chip over a two-wire clock/data link. A command transmitter sends the read command first. Then one pulse on `rd_start` hands the link to this block. The block opens with one quiet state. It then clocks fifteen bit periods out of the chip and collects the ten value bits from the middle of that stream. It closes with three trailer clock patterns and publishes the value together with a one-cycle valid strobe.

Each link state lasts `STATE_CYC` system clocks. The chip switches its output pad on only after it sees a falling clock edge. For that reason the first bit is taken after a complete clock pulse, once the line is low again. Every later bit is taken near the end of its clock-high state. The returned data pin passes through a two-flop synchronizer before it is sampled. With the default timing this leaves exactly enough margin inside one state. A set-DAC operation can run a readback straight away, and a new `rd_start` in the final trailer cycle chains two reads with no gap.

Top module: `dacrb_rx`

## Requirements
- R1: After reset `rd_value` is 0 and `rd_valid` is low, and whenever no read is in progress both `line_clk` and `line_dat` are low.
- R2: `rd_start` is accepted at a clock edge where the block is idle. A read opens with one state of `STATE_CYC` cycles in which both lines are low, so `line_clk` first rises `STATE_CYC+1` cycles after the accepting edge.
- R3: For the first bit, `line_clk` stays high for one state and then low for one state. The input is sampled at the end of that low state, after the falling edge, so any value the chip drives before its first falling edge is never used.
- R4: For each of the 14 later bits, `line_clk` is high for one state and the input is sampled at the end of that state while the clock is still high. The clock then stays low for one state, so the second rising edge comes `STATE_CYC` cycles after the first falling edge.
- R5: Of the 15 bits in arrival order, positions 2 to 11 (counting from 0) form `rd_value`, with the earliest of them as bit 9 (MSB first). The 2 leading and 3 trailing bits have no effect on the result.
- R6: After the 15th bit the block sends three trailer patterns. Each pattern is five states, written as (data, clock): (0,0), (1,0), (1,1), (0,1), (0,0). A read therefore shows 18 rising edges on `line_clk` and exactly 3 rising edges on `line_dat`, with data low throughout the read bits.
- R7: `rd_valid` is a one-cycle pulse that rises `STATE_CYC*46` cycles (184 by default) after the accepting edge. `rd_value` changes only in the cycle where `rd_valid` is high and otherwise holds its last value.
- R8: `rd_start` asserted during a read, other than in its final cycle, is ignored. The read runs to its normal end and no further read follows.
- R9: `rd_start` asserted in the final cycle of a read is accepted. The next read's idle state follows with no gap, and the finishing read still delivers its valid pulse and value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_start | input | 1 | Request to run one readback sequence |
| line_din | input | 1 | Serial data returned by the chip (asynchronous) |
| line_clk | output | 1 | Link clock driven to the chip |
| line_dat | output | 1 | Link data driven to the chip |
| rd_value | output | VAL_W | Last value read back, MSB first on the wire |
| rd_valid | output | 1 | One-cycle strobe marking a new `rd_value` |

## Verification
The completion of one read and the acceptance of the next can happen in the same cycle. In that cycle the final trailer state ends, the collected value is published and a waiting `rd_start` restarts the sequencer and clears the bit counter. The bench provokes this by calling its read task a second time right after the first returns, so the new request is presented exactly in the last trailer cycle. It then judges the result from the scoreboard: both values must arrive, each valid must fall on its own predicted cycle (exactly 184 cycles apart), and the per-read edge counts and first-edge timing of the second read must match a read started from idle.

// File: rtl/dacrb_pkg.sv
package dacrb_pkg;

    localparam int unsigned DEF_STATE_CYC  = 4;
    localparam int unsigned DEF_VAL_W      = 10;
    localparam int unsigned DEF_LEAD_BITS  = 2;
    localparam int unsigned DEF_TRAIL_BITS = 3;
    localparam int unsigned DEF_TAIL_CYC   = 3;
    localparam int unsigned TAIL_STATES    = 5;

    // Line levels and strobes for one link state
    typedef struct packed {
        logic clk;
        logic dat;
        logic smp;
        logic first;
    } link_step_t;

    // Step 0: quiet state. Steps 1..2*nbits: bit periods (high, low).
    // Remaining steps: trailer patterns of TAIL_STATES states each.
    function automatic link_step_t decode_step(int unsigned step, int unsigned nbits);
        link_step_t  o;
        int unsigned r;
        int unsigned t;
        o = '0;
        if (step == 0) begin
            o = '0;
        end else if (step <= 2 * nbits) begin
            r       = step - 1;
            o.first = (r < 2);
            if ((r % 2) == 0) begin
                o.clk = 1'b1;
                o.smp = (r != 0);
            end else begin
                o.clk = 1'b0;
                o.smp = (r == 1);
            end
        end else begin
            t = (step - 1 - 2 * nbits) % TAIL_STATES;
            case (t)
                1:       o.dat = 1'b1;
                2:       begin o.dat = 1'b1; o.clk = 1'b1; end
                3:       o.clk = 1'b1;
                default: o = '0;
            endcase
        end
        return o;
    endfunction

endpackage

// File: rtl/dacrb_sync.sv
module dacrb_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dacrb_seq.sv
module dacrb_seq
    import dacrb_pkg::*;
#(
    parameter int unsigned STATE_CYC  = DEF_STATE_CYC,
    parameter int unsigned TOTAL_BITS = DEF_LEAD_BITS + DEF_VAL_W + DEF_TRAIL_BITS,
    parameter int unsigned TAIL_CYC   = DEF_TAIL_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic accept,
    output logic smp,
    output logic done,
    output logic line_clk,
    output logic line_dat
);
    localparam int unsigned NSTEPS = 1 + 2 * TOTAL_BITS + TAIL_STATES * TAIL_CYC;
    localparam int unsigned STEP_W = $clog2(NSTEPS);
    localparam int unsigned CNT_W  = $clog2(STATE_CYC);

    logic              busy_q;
    logic [STEP_W-1:0] step_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              clk_q, dat_q, past_ok_q;
    logic              last_cnt, last_step;
    link_step_t        dec;

    assign dec       = decode_step(32'(step_q), TOTAL_BITS);
    assign last_cnt  = (cnt_q == CNT_W'(STATE_CYC - 1));
    assign last_step = (step_q == STEP_W'(NSTEPS - 1));
    assign done      = busy_q && last_cnt && last_step;
    assign accept    = start && (!busy_q || done);
    assign smp       = busy_q && last_cnt && dec.smp;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            step_q    <= '0;
            cnt_q     <= '0;
            clk_q     <= 1'b0;
            dat_q     <= 1'b0;
            past_ok_q <= 1'b0;
        end else begin
            past_ok_q <= 1'b1;
            if (accept) begin
                busy_q <= 1'b1;
                step_q <= '0;
                cnt_q  <= '0;
            end else if (busy_q) begin
                if (last_cnt) begin
                    cnt_q <= '0;
                    if (last_step) busy_q <= 1'b0;
                    else           step_q <= step_q + 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            clk_q <= busy_q & dec.clk;
            dat_q <= busy_q & dec.dat;
        end
    end

    assign line_clk = clk_q;
    assign line_dat = dat_q;

    // R3: the first bit is taken only after the clock has fallen
    p_first_sample_low_r3: assert property (@(posedge clk) disable iff (rst)
        smp && dec.first |-> !clk_q);

    // R4: later bits are taken while the clock line is high
    p_later_sample_high_r4: assert property (@(posedge clk) disable iff (rst)
        smp && !dec.first |-> clk_q);

    // R1: lines are low once the sequencer has been idle
    p_idle_lines_low_r1: assert property (@(posedge clk) disable iff (rst)
        past_ok_q && !$past(busy_q) |-> !clk_q && !dat_q);

    // R8: a request in mid-read does not restart the sequence
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        busy_q && !done && start && (step_q != '0) |=> step_q != '0);
endmodule

// File: rtl/dacrb_collect.sv
module dacrb_collect #(
    parameter int unsigned VAL_W      = 10,
    parameter int unsigned LEAD_BITS  = 2,
    parameter int unsigned TOTAL_BITS = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             smp,
    input  logic             bit_in,
    input  logic             done,
    output logic [VAL_W-1:0] value,
    output logic             valid
);
    localparam int unsigned IDX_W = $clog2(TOTAL_BITS + 1);

    logic [IDX_W-1:0] idx_q;
    logic [VAL_W-1:0] shreg_q, value_q;
    logic             valid_q, past_ok_q;
    logic             in_window;

    assign in_window = (idx_q >= IDX_W'(LEAD_BITS)) && (idx_q < IDX_W'(LEAD_BITS + VAL_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= '0;
            shreg_q   <= '0;
            value_q   <= '0;
            valid_q   <= 1'b0;
            past_ok_q <= 1'b0;
        end else begin
            past_ok_q <= 1'b1;
            valid_q   <= done;
            if (done) value_q <= shreg_q;
            if (clear) begin
                idx_q <= '0;
            end else if (smp) begin
                idx_q <= idx_q + 1'b1;
                if (in_window) shreg_q <= {shreg_q[VAL_W-2:0], bit_in};
            end
        end
    end

    assign value = value_q;
    assign valid = valid_q;

    // R5: exactly the full frame has been sampled when a read ends
    p_bit_count_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> idx_q == IDX_W'(TOTAL_BITS));

    // R7: valid is a single-cycle strobe
    p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    // R7: the result only moves together with valid
    p_value_hold_r7: assert property (@(posedge clk) disable iff (rst)
        past_ok_q && !valid_q |-> $stable(value_q));
endmodule

// File: rtl/dacrb_rx.sv
module dacrb_rx
    import dacrb_pkg::*;
#(
    parameter int unsigned STATE_CYC   = DEF_STATE_CYC,
    parameter int unsigned VAL_W       = DEF_VAL_W,
    parameter int unsigned LEAD_BITS   = DEF_LEAD_BITS,
    parameter int unsigned TRAIL_BITS  = DEF_TRAIL_BITS,
    parameter int unsigned TAIL_CYC    = DEF_TAIL_CYC,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_start,
    input  logic             line_din,
    output logic             line_clk,
    output logic             line_dat,
    output logic [VAL_W-1:0] rd_value,
    output logic             rd_valid
);
    localparam int unsigned TOTAL_BITS = LEAD_BITS + VAL_W + TRAIL_BITS;

    logic din_s, accept, smp, done;

    dacrb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (line_din),
        .q   (din_s)
    );

    dacrb_seq #(
        .STATE_CYC (STATE_CYC),
        .TOTAL_BITS(TOTAL_BITS),
        .TAIL_CYC  (TAIL_CYC)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (rd_start),
        .accept  (accept),
        .smp     (smp),
        .done    (done),
        .line_clk(line_clk),
        .line_dat(line_dat)
    );

    dacrb_collect #(
        .VAL_W     (VAL_W),
        .LEAD_BITS (LEAD_BITS),
        .TOTAL_BITS(TOTAL_BITS)
    ) u_collect (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .smp   (smp),
        .bit_in(din_s),
        .done  (done),
        .value (rd_value),
        .valid (rd_valid)
    );
endmodule

// File: tb/dacrb_rx_tb.sv
`timescale 1ns/1ps
module dacrb_rx_tb;
    localparam int SC     = 4;
    localparam int NB     = 15;
    localparam int RD_CYC = (1 + 2 * NB + 5 * 3) * SC;

    logic       clk = 1'b0, rst = 1'b1, start = 1'b0, din = 1'b0;
    logic       line_clk, line_dat, valid;
    logic [9:0] value;

    always #2 clk = ~clk;

    dacrb_rx u_dut (
        .clk(clk), .rst(rst), .rd_start(start), .line_din(din),
        .line_clk(line_clk), .line_dat(line_dat),
        .rd_value(value), .rd_valid(valid)
    );

    int checks = 0, errors = 0, cyc = 0;
    always @(posedge clk) cyc++;

    // Chip model: pad turns on at the first falling edge, later bits follow rising edges
    logic [14:0] frame = '0;
    int rc = 0, fc = 0, dr = 0, t_r1 = 0, t_f1 = 0, t_r2 = 0;
    always @(posedge line_clk) begin
        rc++;
        if (rc == 1) t_r1 = cyc;
        if (rc == 2) t_r2 = cyc;
        if (rc >= 2 && rc <= 15) din = frame[15 - rc];
    end
    always @(negedge line_clk) begin
        fc++;
        if (fc == 1) begin t_f1 = cyc; din = frame[14]; end
    end
    always @(posedge line_dat) dr++;

    typedef struct { logic [9:0] val; int at; } exp_t;
    exp_t       sb[$];
    logic [9:0] last_val = '0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Driver: one read; returns at time #1 into the read's final cycle
    task automatic do_read(logic [9:0] v, logic [1:0] ld, logic [2:0] tr);
        int ca;
        @(negedge clk);
        frame = {ld, v, tr};
        din   = ~frame[14];
        rc = 0; fc = 0; dr = 0;
        start = 1'b1;
        @(posedge clk); #1 ca = cyc;
        @(negedge clk); start = 1'b0;
        repeat (RD_CYC - 1) @(posedge clk);
        #1;
        chk("R2 first rise delay", t_r1 - ca, SC + 1);
        chk("R3 first pulse high time", t_f1 - t_r1, SC);
        chk("R4 second rise after first fall", t_r2 - t_f1, SC);
        chk("R6 clock rises per read", rc, NB + 3);
        chk("R6 data rises per read", dr, 3);
        sb.push_back('{v, ca + RD_CYC});
    endtask

    // Monitor: pop expected items as valid strobes appear
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (valid) begin
                    if (sb.size() == 0) begin
                        chk("R8 unexpected valid", 1, 0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        chk("R5 value", int'(value), int'(e.val));
                        chk("R7 valid cycle", cyc, e.at);
                    end
                    last_val = value;
                end else if (value !== last_val) begin
                    chk("R7 value held", int'(value), int'(last_val));
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 reset clk line", int'(line_clk), 0);
        chk("R1 reset data line", int'(line_dat), 0);
        chk("R1 reset valid", int'(valid), 0);
        chk("R1 reset value", int'(value), 0);

        // R5: junk lead/trail bits must not leak into the value
        do_read(10'h2A5, 2'b11, 3'b111);
        repeat (8) @(posedge clk);
        do_read(10'h000, 2'b11, 3'b101);
        repeat (8) @(posedge clk);
        do_read(10'h3FF, 2'b00, 3'b000);
        repeat (8) @(posedge clk);

        // R8: request in mid-read is ignored
        fork
            do_read(10'h155, 2'b10, 3'b010);
            begin
                repeat (60) @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        repeat (30) @(negedge clk);
        chk("R8 no restart after mid-read request", rc, NB + 3);
        chk("R8 scoreboard drained", sb.size(), 0);

        // R9: back-to-back reads chained in the final cycle
        do_read(10'h0F0, 2'b01, 3'b110);
        do_read(10'h30F, 2'b10, 3'b001);
        repeat (10) @(negedge clk);
        chk("R9 scoreboard drained", sb.size(), 0);
        chk("R9 second value kept", int'(value), 'h30F);
        chk("R1 idle clk line", int'(line_clk), 0);
        chk("R1 idle data line", int'(line_dat), 0);
        summary();
    end
endmodule